// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit gathers the one-cycle event pulses of an I2C controller's protocol engine into a sticky status word. The events are arbitration loss, missing acknowledge, access done, receive and transmit ready, receive and transmit drain, overrun and underflow. A matching enable word masks these flags, and a single registered interrupt line is driven from the result. Software clears a flag by writing a one to its position in the status word.

A second, older view of the same events is an encoded vector. Reading it returns the code of the most urgent enabled event and clears that event in the same access. The status word also shows three live flags: bus busy, general-call (address zero) detected and addressed-as-slave. These follow their inputs and cannot be cleared. Software reaches all of this through a small word-addressed register port with one-cycle read latency.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset the enable word, the sticky status flags and the vector all read as zero, and irq_o is low.
- R2: A pulse on ev_i[b] sets status bit b for b in {0 arb-lost, 1 nack, 2 access-ready, 3 rx-ready, 4 tx-ready, 10 underflow, 11 overrun, 13 rx-drain, 14 tx-drain}. The bit stays set until it is cleared. Pulses on any other ev_i bit have no effect.
- R3: A write to the status word (address 1) clears every sticky bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an event pulse and a clear of the same bit (a write-one or a vector read) fall in the same cycle, the bit remains set.
- R5: The enable word (address 0) stores only bits 0-4, 13 and 14. All other bits read as 0.
- R6: irq_o is high in the cycle after any cycle in which some status bit and its enable bit are both set, and low otherwise.
- R7: A vector read (address 2) returns 0 when no event is pending. Otherwise it returns 1 for arb-lost, 2 for nack, 3 for access-ready, 4 for rx-ready or 5 for tx-ready, choosing the lowest-numbered one. Only events whose status bit and enable bit are both set count as pending.
- R8: A vector read clears exactly the status bit of the event it reports. All other bits are kept.
- R9: Status bits 8, 9 and 12 show addr_zero_i, addr_match_i and bus_busy_i as they are in the read cycle. Writing ones to these bits has no effect.
- R10: rdata_o carries the value read in the previous cycle when that cycle held a read request, and is 0 otherwise. Reads of address 3 return 0, and writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ev_i | input | 16 | event pulses, one per status bit position |
| bus_busy_i | input | 1 | live bus-busy level |
| addr_zero_i | input | 1 | live general-call address seen |
| addr_match_i | input | 1 | live addressed-as-slave level |
| req_i | input | 1 | register access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 2 | word address: 0 enable, 1 status, 2 vector, 3 unused |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data, one cycle after the request |
| irq_o | output | 1 | registered interrupt request |

## Verification
The collisions that matter are an event pulse landing in the same cycle as a clear of the same flag. The clear can come from a write-one to the status word or from a vector read that picks that flag. Directed steps force both collisions on one bit. The random phase then drives dense event pulses while the register port issues status writes and vector reads. A bench model applies set-over-clear and checks the next read and the next irq_o value.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W = 16;

  localparam int B_AL   = 0;
  localparam int B_NACK = 1;
  localparam int B_ARDY = 2;
  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_AD0  = 8;
  localparam int B_AAS  = 9;
  localparam int B_XUDF = 10;
  localparam int B_ROVR = 11;
  localparam int B_BB   = 12;
  localparam int B_RDR  = 13;
  localparam int B_XDR  = 14;

  localparam logic [REG_W-1:0] STICKY_M = 16'h6C1F;
  localparam logic [REG_W-1:0] EN_M     = 16'h601F;

  // vector sources are the lowest status bits, AL first
  localparam int NUM_SRC = 5;

  typedef enum logic [1:0] {
    RA_EN   = 2'd0,
    RA_STS  = 2'd1,
    RA_VEC  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int                 W     = 16,
  parameter logic [W-1:0]       SET_M = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r[i] <= 1'b0;
      else         q_r[i] <= SET_M[i] & (set_i[i] | (q_r[i] & ~clr_i[i]));
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int N  = 5,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  onehot_o
);
  // lowest index wins: scan downward, last hit overrides
  always_comb begin
    code_o   = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o   = CW'(i + 1);
        onehot_o = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] sts_view_i,
  input  logic [REG_W-1:0] vec_val_i,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] w1c_o,
  output logic             vec_rd_o,
  output logic [REG_W-1:0] rdata_o
);
  reg_addr_e        ra;
  logic             wr, rd;
  logic [REG_W-1:0] en_q, rmux, rdata_q;

  assign ra = reg_addr_e'(addr_i);
  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= '0;
    else if (wr && ra == RA_EN)  en_q <= wdata_i & EN_M;
  end

  assign w1c_o    = (wr && ra == RA_STS) ? wdata_i : '0;
  assign vec_rd_o = rd && ra == RA_VEC;

  always_comb begin
    unique case (ra)
      RA_EN:   rmux = en_q;
      RA_STS:  rmux = sts_view_i;
      RA_VEC:  rmux = vec_val_i;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rmux : '0;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  ev_i,
  input  logic              bus_busy_i,
  input  logic              addr_zero_i,
  input  logic              addr_match_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int CODE_W = $clog2(NUM_SRC + 1);

  logic [REG_W-1:0]   sts_q, en_q, w1c, vec_clr, clr, live, sts_view, vec_val;
  logic [NUM_SRC-1:0] pend, pick;
  logic [CODE_W-1:0]  code;
  logic               vec_rd, irq_q;

  always_comb begin
    live          = '0;
    live[B_AD0]   = addr_zero_i;
    live[B_AAS]   = addr_match_i;
    live[B_BB]    = bus_busy_i;
  end

  assign sts_view = sts_q | live;
  assign pend     = sts_q[NUM_SRC-1:0] & en_q[NUM_SRC-1:0];
  assign vec_val  = {{(REG_W-CODE_W){1'b0}}, code};
  assign vec_clr  = {{(REG_W-NUM_SRC){1'b0}}, pick & {NUM_SRC{vec_rd}}};
  assign clr      = w1c | vec_clr;

  i2c_irq_flags #(.W(REG_W), .SET_M(STICKY_M)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_i),
    .clr_i  (clr),
    .q_o    (sts_q)
  );

  i2c_irq_prio #(.N(NUM_SRC)) u_prio (
    .req_i    (pend),
    .code_o   (code),
    .onehot_o (pick)
  );

  i2c_irq_regif u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .sts_view_i (sts_view),
    .vec_val_i  (vec_val),
    .en_o       (en_q),
    .w1c_o      (w1c),
    .vec_rd_o   (vec_rd),
    .rdata_o    (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts_q & en_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] ev_i,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             irq_o,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] en_q
);
  logic sts_wr, vec_rd;
  assign sts_wr = req_i & we_i & (addr_i == 2'd1);
  assign vec_rd = req_i & ~we_i & (addr_i == 2'd2);

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(ev_i & STICKY_M) |=> ((sts_q & $past(ev_i & STICKY_M)) == $past(ev_i & STICKY_M)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr |=> ((sts_q & $past(wdata_i & ~ev_i)) == '0));

  a_r4_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && (wdata_i & ev_i & STICKY_M) != '0)
      |=> ((sts_q & $past(wdata_i & ev_i & STICKY_M)) == $past(wdata_i & ev_i & STICKY_M)));

  a_r5_enable_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~EN_M) == '0);

  a_r6_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(sts_q & en_q))));

  a_r8_vec_clears_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && (sts_q[NUM_SRC-1:0] & en_q[NUM_SRC-1:0]) != '0 && ev_i[NUM_SRC-1:0] == '0)
      |=> ($countones(sts_q[NUM_SRC-1:0]) + 1 == $countones($past(sts_q[NUM_SRC-1:0]))));

  a_r10_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ev_i    (ev_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .en_q    (en_q)
);

// File: tb/sim_i2c_irq_unit.sv
`timescale 1ns/1ps
module sim_i2c_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ev_i = '0;
  logic        bus_busy_i = 1'b0, addr_zero_i = 1'b0, addr_match_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] sts_m = '0, en_m = '0;

  localparam logic [15:0] STK = 16'h6C1F;
  localparam logic [15:0] ENM = 16'h601F;

  always #2 clk_i = ~clk_i;

  i2c_irq_unit u0 (.*);

  function automatic logic [15:0] live_m();
    return {3'b0, bus_busy_i, 2'b0, addr_match_i, addr_zero_i, 8'h00};
  endfunction

  function automatic int code_m(logic [15:0] s, logic [15:0] e);
    for (int i = 0; i < 5; i++) if (s[i] & e[i]) return i + 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, sample 1ns after posedge
  task automatic step(string tag, logic [15:0] ev, logic rq, logic w,
                      logic [1:0] a, logic [15:0] wd);
    logic [15:0] clr, rexp, nsts;
    logic        iexp;
    @(negedge clk_i);
    ev_i = ev; req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    #0.1;
    iexp = |(sts_m & en_m);
    clr  = '0;
    rexp = '0;
    if (rq && !w) begin
      case (a)
        2'd0: rexp = en_m;
        2'd1: rexp = sts_m | live_m();
        2'd2: begin
          rexp = 16'(code_m(sts_m, en_m));
          if (rexp != 0) clr[rexp-1] = 1'b1;
        end
        default: rexp = '0;
      endcase
    end
    if (rq && w && a == 2'd1) clr = wd;
    nsts = ((sts_m & ~clr) | ev) & STK;
    if (rq && w && a == 2'd0) en_m = wd & ENM;
    sts_m = nsts;
    @(posedge clk_i); #1;
    chk({tag, " rdata"}, rdata_o, rexp);
    chk({tag, " irq"}, {15'b0, irq_o}, {15'b0, iexp});
  endtask

  task automatic rd(string tag, logic [1:0] a);  step(tag, '0, 1, 0, a, '0); endtask
  task automatic wr(string tag, logic [1:0] a, logic [15:0] d); step(tag, '0, 1, 1, a, d); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c2d));
    #9 rst_ni = 1'b1;
    // R1 reset state
    #1 chk("R1 irq", {15'b0, irq_o}, 16'h0);
    rd("R1 en", 2'd0); rd("R1 sts", 2'd1); rd("R1 vec", 2'd2);
    // R2 all event lines pulsed, only sticky ones stick
    step("R2 pulse", 16'hFFFF, 0, 0, 0, 0);
    rd("R2 sts", 2'd1);
    // R3 write-one clears, zero keeps
    wr("R3 w1c", 2'd1, 16'h0003); rd("R3 sts", 2'd1);
    wr("R3 w0", 2'd1, 16'h0000); rd("R3 keep", 2'd1);
    // R4 event wins over write-one-to-clear
    step("R4 w1c+ev", 16'h0004, 1, 1, 2'd1, 16'h0004); rd("R4 sts", 2'd1);
    // R5 enable mask, R6 irq rises
    wr("R5 en", 2'd0, 16'hFFFF); rd("R5 en", 2'd0); rd("R6 irq", 2'd1);
    // R7/R8 priority and clear on vector read
    rd("R7 vec3", 2'd2); rd("R8 sts", 2'd1);
    rd("R7 vec4", 2'd2); rd("R7 vec5", 2'd2); rd("R7 vec0", 2'd2);
    step("R7 al+xrdy", 16'h0011, 0, 0, 0, 0); rd("R7 al", 2'd2); rd("R7 xrdy", 2'd2);
    // R4 event on the bit a vector read clears
    step("R4 ev", 16'h0002, 0, 0, 0, 0);
    step("R4 vec+ev", 16'h0002, 1, 0, 2'd2, 0); rd("R4 kept", 2'd1);
    // R7 masked source skipped
    wr("R7 en", 2'd0, 16'h0004); step("R7 ev", 16'h0005, 0, 0, 0, 0);
    rd("R7 masked", 2'd2); wr("R6 clr", 2'd1, 16'hFFFF); rd("R6 low", 2'd1);
    // R9 live flags not clearable
    bus_busy_i = 1; addr_zero_i = 1; addr_match_i = 1;
    wr("R9 w1c", 2'd1, 16'h1300); rd("R9 live", 2'd1);
    bus_busy_i = 0; rd("R9 drop", 2'd1);
    // R10 unused address, idle cycles, vector write ignored
    wr("R10 wvec", 2'd2, 16'hFFFF); wr("R10 w3", 2'd3, 16'hFFFF);
    rd("R10 a3", 2'd3); step("R10 idle", '0, 0, 0, 0, 0); rd("R10 en", 2'd0);
    // random mix, R2-R10 against the model
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ev;
      ev = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      bus_busy_i = 1'($urandom); addr_zero_i = 1'($urandom); addr_match_i = 1'($urandom);
      step("R6/R10 rand", ev, 1'($urandom), 1'(($urandom % 3) == 0),
           2'($urandom), 16'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule